// File: doc/BRIEF.md
# Vital Product Data Capability Controller

This block implements a configuration-space capability that lets software reach vital product data kept in an external serial EEPROM without touching the EEPROM bus itself. The capability occupies two dword slots. The control dword holds the capability identifier, a link to the next capability, a 6-bit dword-aligned VPD address and a direction/completion flag. The data dword carries four bytes of VPD.

Software first programs the address. It then writes the flag: a 0 requests a 4-byte read and a 1 requests a 4-byte write. The block sends a single-cycle request to an EEPROM engine and holds the flag until the engine reports that it has finished. At that point the flag is inverted, so a read ends with the flag at 1 and a write ends with it at 0. Software polls the flag to learn that the cycle has completed. Read data is loaded into the data dword, and write data is taken from it. The EEPROM byte address is the VPD byte address shifted up by 0x40.

Top module: `vpd_cap_ctrl`

## Requirements
- R1: A read of the control dword (dword index 0x3A, byte offset E8h) returns 8'h03 in bits 7:0, and config writes never change that byte.
- R2: Bits 15:8 of the control dword read 8'hE4 when `hs_strap` is 1 and 8'h00 when it is 0.
- R3: The VPD address is a 6-bit field at bits 23:18 of the control dword. It is written when byte enable 2 is set. Bits 17:16 and 30:24 always read 0, whatever was written to them.
- R4: A write to the control dword with byte enable 3 set and bit 31 = 0 starts a read. On the next cycle `eep_start` is high for exactly one cycle with `eep_dir` = 0. The flag reads 0 until `eep_done` arrives and reads 1 after it.
- R5: A write with byte enable 3 set and bit 31 = 1 starts a write. The request carries `eep_dir` = 1 and `eep_wdata` equal to the data dword. The flag reads 1 until `eep_done` arrives and reads 0 after it.
- R6: `eep_addr` equals 4 × (VPD address) + 0x40, taken modulo 256.
- R7: The data dword sits at dword index 0x3B (byte offset ECh). A config write there updates only the bytes whose enable bit is set. Byte 0 (bits 7:0) maps to the lowest EEPROM address of the four.
- R8: When a read completes, all four bytes of the data dword are loaded from `eep_rdata`. If a config write to the data dword falls in the same cycle, the loaded read data wins.
- R9: While a cycle is pending (from the start pulse through the cycle in which `eep_done` is seen), writes to the control dword are ignored. They change neither the address nor the flag, and they issue no request.
- R10: After reset the address, flag and data dword are all 0, and `eep_start` is low.
- R11: When `cfg_rd` is low or the dword index matches neither slot, `cfg_rdata` is 0. `cfg_hit` is high only for a read or write of one of the two slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_strap | input | 1 | Hot-swap enable strap; selects the next-capability link |
| cfg_rd | input | 1 | Config read strobe |
| cfg_wr | input | 1 | Config write strobe |
| cfg_dw_addr | input | 6 | Config dword index (byte offset >> 2) |
| cfg_be | input | 4 | Config write byte enables |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data (combinational) |
| cfg_hit | output | 1 | Access targets this capability |
| eep_start | output | 1 | One-cycle request pulse to the EEPROM engine |
| eep_dir | output | 1 | Request direction, 0 read, 1 write |
| eep_addr | output | 8 | EEPROM byte address of the first byte |
| eep_wdata | output | 32 | Write data, byte 0 at the lowest address |
| eep_done | input | 1 | One-cycle completion pulse from the engine |
| eep_rdata | input | 32 | Read data, valid with `eep_done` |

## Verification
Two events can land on the same clock edge: the engine's completion pulse and a software config write. The bench watches for the completion pulse at the falling edge and, in that same half cycle, drives a config write. It does this once with an all-ones write to the data dword, where the returned EEPROM bytes must survive. It does it once with a new read command to the control dword, which must leave the address unchanged, leave the flag at its completed value and issue no second request to the engine.

// File: rtl/vpdc_pkg.sv
package vpdc_pkg;

    localparam int unsigned CFG_DW_W  = 6;
    localparam int unsigned VPD_AW    = 6;
    localparam int unsigned EEP_AW    = 8;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned NBYTES    = DATA_W / 8;

    localparam logic [CFG_DW_W-1:0] CTL_DW   = 6'h3A;
    localparam logic [CFG_DW_W-1:0] DAT_DW   = 6'h3B;
    localparam logic [7:0]          CAP_ID   = 8'h03;
    localparam logic [7:0]          NEXT_HS  = 8'hE4;
    localparam logic [EEP_AW-1:0]   EEP_BASE = 8'h40;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } vpd_dir_e;

    typedef logic [VPD_AW-1:0] vpd_addr_t;

    typedef struct packed {
        vpd_dir_e           dir;
        logic [EEP_AW-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
    } eep_req_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_DAT  = 2'd2
    } slot_sel_e;

    function automatic logic [EEP_AW-1:0] eep_byte_addr(vpd_addr_t a);
        logic [EEP_AW-1:0] b;
        b = EEP_AW'({a, 2'b00});
        return b + EEP_BASE;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctl(logic flag, vpd_addr_t a, logic strap);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[31]    = flag;
        w[23:18] = a;
        w[15:8]  = strap ? NEXT_HS : 8'h00;
        w[7:0]   = CAP_ID;
        return w;
    endfunction

endpackage

// File: rtl/vpd_cfg_decode.sv
module vpd_cfg_decode
    import vpdc_pkg::*;
(
    input  logic                 cfg_rd,
    input  logic                 cfg_wr,
    input  logic [CFG_DW_W-1:0]  cfg_dw_addr,
    input  logic                 flag,
    input  vpd_addr_t            addr,
    input  logic                 hs_strap,
    input  logic [DATA_W-1:0]    data,
    output logic                 ctl_we,
    output logic                 dat_we,
    output logic                 hit,
    output logic [DATA_W-1:0]    rdata
);

    slot_sel_e sel;

    always_comb begin
        unique case (cfg_dw_addr)
            CTL_DW:  sel = SEL_CTL;
            DAT_DW:  sel = SEL_DAT;
            default: sel = SEL_NONE;
        endcase
    end

    assign ctl_we = cfg_wr && (sel == SEL_CTL);
    assign dat_we = cfg_wr && (sel == SEL_DAT);
    assign hit    = (cfg_rd || cfg_wr) && (sel != SEL_NONE);

    always_comb begin
        rdata = '0;
        if (cfg_rd) begin
            case (sel)
                SEL_CTL: rdata = pack_ctl(flag, addr, hs_strap);
                SEL_DAT: rdata = data;
                default: rdata = '0;
            endcase
        end
    end

    // R11: read data is quiet without a read strobe
    always_comb begin
        if (!cfg_rd) begin
            a_r11_quiet_idle: assert (rdata == '0);
        end
    end

endmodule

// File: rtl/vpd_ctl_reg.sv
module vpd_ctl_reg
    import vpdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       be_addr,
    input  logic       be_flag,
    input  vpd_addr_t  wr_addr,
    input  logic       wr_flag,
    input  logic       eep_done,
    output vpd_addr_t  addr,
    output logic       flag,
    output logic       busy,
    output logic       start,
    output logic       rd_load
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            flag  <= 1'b0;
            busy  <= 1'b0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            if (busy) begin
                if (eep_done) begin
                    busy <= 1'b0;
                    flag <= ~flag;
                end
            end else if (wr_en) begin
                if (be_addr) addr <= wr_addr;
                if (be_flag) begin
                    flag  <= wr_flag;
                    busy  <= 1'b1;
                    start <= 1'b1;
                end
            end
        end
    end

    assign rd_load = busy && eep_done && (vpd_dir_e'(flag) == DIR_READ);

    // R4: the request is a single-cycle pulse
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    // R9: pending cycle locks address and flag
    a_r9_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && !eep_done) |=> ($stable(addr) && $stable(flag) && busy));

    // R9: no new request in the cycle after a pending one
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy |=> !start);

    // R5: completion inverts the flag and frees the block
    a_r5_done_flips: assert property (@(posedge clk) disable iff (rst)
        (busy && eep_done) |=> (flag != $past(flag)) && !busy);

endmodule

// File: rtl/vpd_data_reg.sv
module vpd_data_reg
    import vpdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [NBYTES-1:0]  be,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rd_load,
    input  logic [DATA_W-1:0]  ld_data,
    output logic [DATA_W-1:0]  data
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                data[8*b +: 8] <= '0;
            end else if (rd_load) begin
                data[8*b +: 8] <= ld_data[8*b +: 8];
            end else if (wr_en && be[b]) begin
                data[8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    // R8: completed read loads every byte, over any config write
    a_r8_load_all: assert property (@(posedge clk) disable iff (rst)
        rd_load |=> (data == $past(ld_data)));

    // R7: without a write or load the dword holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !rd_load) |=> $stable(data));

endmodule

// File: rtl/vpd_cap_ctrl.sv
module vpd_cap_ctrl
    import vpdc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hs_strap,
    input  logic                cfg_rd,
    input  logic                cfg_wr,
    input  logic [5:0]          cfg_dw_addr,
    input  logic [3:0]          cfg_be,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output logic                cfg_hit,
    output logic                eep_start,
    output logic                eep_dir,
    output logic [7:0]          eep_addr,
    output logic [31:0]         eep_wdata,
    input  logic                eep_done,
    input  logic [31:0]         eep_rdata
);

    vpd_addr_t          addr;
    logic               flag;
    logic               busy;
    logic               start;
    logic               rd_load;
    logic               ctl_we;
    logic               dat_we;
    logic [DATA_W-1:0]  data;
    eep_req_t           req;

    vpd_cfg_decode u_decode (
        .cfg_rd      (cfg_rd),
        .cfg_wr      (cfg_wr),
        .cfg_dw_addr (cfg_dw_addr),
        .flag        (flag),
        .addr        (addr),
        .hs_strap    (hs_strap),
        .data        (data),
        .ctl_we      (ctl_we),
        .dat_we      (dat_we),
        .hit         (cfg_hit),
        .rdata       (cfg_rdata)
    );

    vpd_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctl_we),
        .be_addr  (cfg_be[2]),
        .be_flag  (cfg_be[3]),
        .wr_addr  (cfg_wdata[23:18]),
        .wr_flag  (cfg_wdata[31]),
        .eep_done (eep_done),
        .addr     (addr),
        .flag     (flag),
        .busy     (busy),
        .start    (start),
        .rd_load  (rd_load)
    );

    vpd_data_reg u_data (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dat_we),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .rd_load (rd_load),
        .ld_data (eep_rdata),
        .data    (data)
    );

    always_comb begin
        req.dir   = vpd_dir_e'(flag);
        req.addr  = eep_byte_addr(addr);
        req.wdata = data;
    end

    assign eep_start = start;
    assign eep_dir   = req.dir;
    assign eep_addr  = req.addr;
    assign eep_wdata = req.wdata;

    // R1: identifier byte of the control dword is fixed
    a_r1_cap_id: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && cfg_dw_addr == CTL_DW) |-> (cfg_rdata[7:0] == CAP_ID));

    // R3: reserved bits of the control dword read zero
    a_r3_reserved: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && cfg_dw_addr == CTL_DW) |-> (cfg_rdata[17:16] == 2'b00 && cfg_rdata[30:24] == 7'd0));

    // R6: request address is dword aligned after the 0x40 offset
    a_r6_aligned: assert property (@(posedge clk) disable iff (rst)
        eep_start |-> (eep_addr[1:0] == 2'b00));

endmodule

// File: tb/vpd_cap_ctrl_bench.sv
module vpd_cap_ctrl_bench;
    import vpdc_pkg::*;

    localparam int LAT = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        hs_strap;
    logic        cfg_rd, cfg_wr;
    logic [5:0]  cfg_dw_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        cfg_hit;
    logic        eep_start, eep_dir;
    logic [7:0]  eep_addr;
    logic [31:0] eep_wdata;
    logic        eep_done;
    logic [31:0] eep_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vpd_cap_ctrl u_vpd_cap_ctrl (
        .clk(clk), .rst(rst), .hs_strap(hs_strap),
        .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_hit(cfg_hit), .eep_start(eep_start), .eep_dir(eep_dir),
        .eep_addr(eep_addr), .eep_wdata(eep_wdata), .eep_done(eep_done),
        .eep_rdata(eep_rdata)
    );

    // ---------------- EEPROM model and scoreboard ----------------
    logic [7:0] mem [256];
    eep_req_t   exp_q [$];
    int         cnt;
    eep_req_t   cur;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    end

    function automatic logic [31:0] mem_word(logic [7:0] a);
        return {mem[8'(a + 3)], mem[8'(a + 2)], mem[8'(a + 1)], mem[a]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            eep_done  <= 1'b0;
            eep_rdata <= '0;
            cnt       <= 0;
        end else begin
            eep_done <= 1'b0;
            if (eep_start) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9 unexpected request dir=%0b addr=%h expected none", eep_dir, eep_addr);
                end else begin
                    eep_req_t e;
                    e = exp_q.pop_front();
                    if (eep_dir != e.dir || eep_addr != e.addr ||
                        (e.dir == DIR_WRITE && eep_wdata != e.wdata)) begin
                        errors++;
                        $display("FAIL R4/R5/R6 request act dir=%0b addr=%h wd=%h exp dir=%0b addr=%h wd=%h",
                                 eep_dir, eep_addr, eep_wdata, e.dir, e.addr, e.wdata);
                    end
                end
                cur.dir   <= vpd_dir_e'(eep_dir);
                cur.addr  <= eep_addr;
                cur.wdata <= eep_wdata;
                cnt       <= LAT;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    eep_done  <= 1'b1;
                    eep_rdata <= mem_word(cur.addr);
                    if (cur.dir == DIR_WRITE) begin
                        for (int k = 0; k < 4; k++) mem[8'(cur.addr + 8'(k))] <= cur.wdata[8*k +: 8];
                    end
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_dw_addr = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0; cfg_be = 0;
    endtask

    task automatic cfg_read(logic [5:0] dw, output logic [31:0] d, output logic h);
        @(negedge clk);
        cfg_rd = 1; cfg_dw_addr = dw;
        #1;
        d = cfg_rdata; h = cfg_hit;
        @(negedge clk);
        cfg_rd = 0;
    endtask

    function automatic logic [31:0] cmd(logic f, logic [5:0] a);
        return {f, 7'h7F, a, 2'b11, 16'hFFFF};
    endfunction

    task automatic wait_flag(logic v, string req);
        logic [31:0] d; logic h; bit ok;
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            cfg_read(CTL_DW, d, h);
            if (d[31] == v) begin ok = 1; break; end
        end
        chk(req, {31'd0, ok}, 32'd1);
    endtask

    task automatic push(vpd_dir_e dir, logic [5:0] a, logic [31:0] wd);
        eep_req_t e;
        e.dir = dir;
        e.addr = 8'({a, 2'b00}) + 8'h40;
        e.wdata = wd;
        exp_q.push_back(e);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog act=running exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] d; logic h;
        rst = 1; hs_strap = 0; cfg_rd = 0; cfg_wr = 0;
        cfg_dw_addr = 0; cfg_be = 0; cfg_wdata = 0;
        repeat (4) @(negedge clk);
        rst = 0;

        // R10 reset state, R1, R2
        chk("R10 start low", {31'd0, eep_start}, 32'd0);
        cfg_read(CTL_DW, d, h);
        chk("R10 R1 ctl reset", d, 32'h0000_0003);
        chk("R11 hit ctl", {31'd0, h}, 32'd1);
        cfg_read(DAT_DW, d, h);
        chk("R10 data reset", d, 32'h0);
        hs_strap = 1;
        cfg_read(CTL_DW, d, h);
        chk("R2 strap high", d, 32'h0000_E403);

        // R3 address only, reserved and fixed bytes unaffected, no request
        cfg_write(CTL_DW, 4'b0111, cmd(1'b1, 6'h2A));
        cfg_read(CTL_DW, d, h);
        chk("R3 R1 addr only", d, {8'h00, 6'h2A, 2'b00, 8'hE4, 8'h03});
        hs_strap = 0;

        // R7 byte enables
        cfg_write(DAT_DW, 4'hF, 32'hA1B2_C3D4);
        cfg_write(DAT_DW, 4'b0101, 32'h1122_3344);
        cfg_read(DAT_DW, d, h);
        chk("R7 byte enables", d, 32'hA122_C344);

        // R5 write cycle at address 5, R9 lock while pending
        push(DIR_WRITE, 6'd5, 32'hA122_C344);
        cfg_write(CTL_DW, 4'b1100, cmd(1'b1, 6'd5));
        cfg_read(CTL_DW, d, h);
        chk("R5 flag held 1", {31'd0, d[31]}, 32'd1);
        cfg_write(CTL_DW, 4'b1100, cmd(1'b0, 6'd9));
        cfg_read(CTL_DW, d, h);
        chk("R9 locked addr", {26'd0, d[23:18]}, 32'd5);
        chk("R9 locked flag", {31'd0, d[31]}, 32'd1);
        wait_flag(1'b0, "R5 write completes to 0");

        // R4 read back address 5, R8 full overwrite
        cfg_write(DAT_DW, 4'hF, 32'h0);
        push(DIR_READ, 6'd5, 32'h0);
        cfg_write(CTL_DW, 4'b1100, cmd(1'b0, 6'd5));
        cfg_read(CTL_DW, d, h);
        chk("R4 flag held 0", {31'd0, d[31]}, 32'd0);
        wait_flag(1'b1, "R4 read completes to 1");
        cfg_read(DAT_DW, d, h);
        chk("R8 R4 readback", d, 32'hA122_C344);

        // R6 wrap at top address
        push(DIR_READ, 6'h3F, 32'h0);
        cfg_write(CTL_DW, 4'b1100, cmd(1'b0, 6'h3F));
        wait_flag(1'b1, "R6 read top");
        cfg_read(DAT_DW, d, h);
        chk("R6 wrapped data", d, mem_word(8'h3C));

        // R8 collision: done and data write in the same cycle
        push(DIR_READ, 6'd2, 32'h0);
        cfg_write(CTL_DW, 4'b1100, cmd(1'b0, 6'd2));
        @(negedge clk);
        while (!eep_done) @(negedge clk);
        cfg_wr = 1; cfg_dw_addr = DAT_DW; cfg_be = 4'hF; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cfg_wr = 0; cfg_be = 0;
        cfg_read(DAT_DW, d, h);
        chk("R8 load wins", d, mem_word(8'h48));

        // R9 collision: done and control write in the same cycle
        push(DIR_READ, 6'd3, 32'h0);
        cfg_write(CTL_DW, 4'b1100, cmd(1'b0, 6'd3));
        @(negedge clk);
        while (!eep_done) @(negedge clk);
        cfg_wr = 1; cfg_dw_addr = CTL_DW; cfg_be = 4'b1100; cfg_wdata = cmd(1'b0, 6'd1);
        @(negedge clk);
        cfg_wr = 0; cfg_be = 0;
        cfg_read(CTL_DW, d, h);
        chk("R9 done-cycle addr", {26'd0, d[23:18]}, 32'd3);
        chk("R9 done-cycle flag", {31'd0, d[31]}, 32'd1);
        repeat (LAT + 5) @(negedge clk);
        chk("R9 no extra request", {31'd0, eep_start}, 32'd0);

        // R11 other slots and idle read
        cfg_read(6'h10, d, h);
        chk("R11 other rdata", d, 32'h0);
        chk("R11 other hit", {31'd0, h}, 32'd0);
        #1;
        chk("R11 idle rdata", cfg_rdata, 32'h0);

        chk("R4 queue drained", exp_q.size(), 32'd0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule